// File: doc/BRIEF.md
# Multi-mode ADC conversion sequencer

This block is the digital control core of a successive-approximation converter with eight analog inputs. Software programs a control word and a channel mask over a simple register port. The sequencer then picks channels, starts the external converter with a one-cycle request, and waits for the converter's done strobe. It formats and files each 12-bit result in a per-channel register and keeps per-channel valid and overrun flags, a busy flag and a sticky completion flag. The completion flag drives the interrupt request.

Conversions start from a start bit in the control word. Software can set that bit directly. When the trigger enable is set, the bit can also be set by an external pin or a PWM trigger line. Each trigger line passes through a two-flop synchroniser and is then tested for a low level, a high level, a falling edge or a rising edge. Four modes are supported: single, burst code (handled exactly like single here), single pass scan and continuous scan.

The converter return path works as a valid-only stream. `conv_done` is the valid and `conv_data` is the payload. There is no ready signal: the block applies no back-pressure. A done strobe is accepted on any cycle in which the sequencer is busy and is not being aborted. A done strobe that arrives while the block is idle is dropped.

Top module: `adc_seq_top`

## Requirements
- R1: After reset, the control word, the channel mask, the status word, `irq` and `conv_start` are all zero.
- R2: With mode 0 (single) or mode 1, the lowest-numbered enabled channel is converted once. The result is stored, the completion flag is set, busy falls and hardware clears the start bit.
- R3: With mode 2, each enabled channel is converted once in ascending order. The start bit is then cleared by hardware, busy falls and the completion flag is set.
- R4: With mode 3, channels are converted in ascending order and the sequence wraps back to the lowest enabled channel. The completion flag is set at each wrap, and conversion continues until software clears the start bit.
- R5: A control write with the start bit 0 while busy drops busy and `conv_start` at that write edge. A later done strobe stores nothing and sets no flag.
- R6: For one cycle after hardware clears the start bit, a software write of start=1 and any trigger event are ignored, and the start bit stays 0.
- R7: Storing a result sets that channel's valid flag. If the valid flag was already set, the overrun flag is also set. Reading a result register clears the channel's valid flag. Writing 1 to an overrun bit of the status word clears that bit.
- R8: When the differential bit and the format bit are both 1, the stored result is the converter code with bit 11 inverted (two's complement). Otherwise the code is stored unchanged.
- R9: While the enable bit is 0, the start bit reads 0, and no conversion starts or stays in progress.
- R10: With trigger enable set, trigger source 0 selects the pin and source 3 selects the PWM line. The condition codes are 0 low level, 1 high level, 2 falling edge and 3 rising edge. A pin change made before clock edge k raises `conv_start` at edge k+3. Edge conditions fire once per edge.
- R11: The completion flag is cleared by writing 1 to status bit 1, and `irq` equals the completion flag.
- R12: Register map. Address 0 is control: bit 0 enable, bits 2:1 mode, bit 3 differential, bit 4 format, bit 5 trigger enable, bits 7:6 source, bits 9:8 condition, bit 10 start. Address 1 is the channel mask. Address 2 is status: bit 0 busy, bit 1 complete, bits 9:2 valid, bits 17:10 overrun. Addresses 8 to 15 hold the results of channels 0 to 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effects on result reads) |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 18 | Write data |
| reg_rdata | output | 18 | Read data, combinational from `reg_addr` |
| trig_pin | input | 1 | External trigger pin, asynchronous |
| trig_pwm | input | 1 | PWM trigger line, asynchronous |
| conv_start | output | 1 | One-cycle request to the converter |
| conv_ch | output | 3 | Channel being converted |
| conv_done | input | 1 | Converter result valid |
| conv_data | input | 12 | Converter result code |
| irq | output | 1 | Interrupt request |

## Verification
A register write takes effect at the clock edge on which `reg_wr` is sampled. A start bit set at edge E raises `conv_start` after edge E+1. A done strobe sampled at edge D updates the result, the valid flag, the overrun flag, the completion flag and busy all at edge D. In the scan modes the next `conv_start` is also raised at edge D. A pin change before edge k shows as `conv_start` after edge k+3. An abort write clears busy at its own edge. The bench drives every input on falling edges and samples outputs one falling edge after the edge where a result is due. For the trigger latency it counts falling edges exactly, and it checks that `conv_start` is still low one edge before the due edge.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [1:0] {
    MD_ONE   = 2'd0,
    MD_BURST = 2'd1,
    MD_SWEEP = 2'd2,
    MD_LOOP  = 2'd3
  } mode_e;

  typedef enum logic [1:0] {
    TC_LOW  = 2'd0,
    TC_HIGH = 2'd1,
    TC_FALL = 2'd2,
    TC_RISE = 2'd3
  } tcond_e;

  // packed from MSB: start is bit 10, enable is bit 0
  typedef struct packed {
    logic       start;
    tcond_e     cond;
    logic [1:0] src;
    logic       trig_en;
    logic       fmt;
    logic       diff;
    mode_e      mode;
    logic       en;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
  localparam logic [1:0] SRC_PIN = 2'd0;
  localparam logic [1:0] SRC_PWM = 2'd3;

endpackage

// File: rtl/adc_trig_det.sv
module adc_trig_det
  import adc_seq_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_i,
  input  logic       pwm_i,
  input  logic       arm_i,
  input  logic [1:0] src_i,
  input  tcond_e     cond_i,
  output logic       fire_o
);

  logic [STAGES-1:0] pin_sh;
  logic [STAGES-1:0] pwm_sh;
  logic              sel;
  logic              src_ok;
  logic              prev_q;
  logic              hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_sh <= '0;
      pwm_sh <= '0;
      prev_q <= 1'b0;
    end else begin
      pin_sh <= {pin_sh[STAGES-2:0], pin_i};
      pwm_sh <= {pwm_sh[STAGES-2:0], pwm_i};
      prev_q <= sel;
    end
  end

  always_comb begin
    sel    = 1'b0;
    src_ok = 1'b0;
    if (src_i == SRC_PIN) begin
      sel    = pin_sh[STAGES-1];
      src_ok = 1'b1;
    end else if (src_i == SRC_PWM) begin
      sel    = pwm_sh[STAGES-1];
      src_ok = 1'b1;
    end
    unique case (cond_i)
      TC_LOW:  hit = !sel;
      TC_HIGH: hit = sel;
      TC_FALL: hit = !sel && prev_q;
      TC_RISE: hit = sel && !prev_q;
      default: hit = 1'b0;
    endcase
    fire_o = arm_i && src_ok && hit;
  end

endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
  import adc_seq_pkg::*;
#(
  parameter  int NCH = 8,
  localparam int CHW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start_i,
  input  logic           en_i,
  input  mode_e          mode_i,
  input  logic [NCH-1:0] mask_i,
  input  logic           abort_i,
  input  logic           done_i,
  output logic           busy_o,
  output logic           conv_start_o,
  output logic [CHW-1:0] conv_ch_o,
  output logic           store_o,
  output logic           hw_clr_o,
  output logic           pass_o
);

  logic           busy_q;
  logic           conv_start_q;
  logic [CHW-1:0] cur_q;
  logic [CHW:0]   first;
  logic [CHW:0]   nxt;
  logic           go;
  logic           cont;
  logic           wrap;

  // {found, index} of the lowest set mask bit at or above lo
  function automatic logic [CHW:0] seek(input logic [NCH-1:0] m, input int lo);
    logic [CHW:0] r;
    r = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if ((i >= lo) && m[i]) r = {1'b1, CHW'(i)};
    end
    return r;
  endfunction

  always_comb begin
    first    = seek(mask_i, 0);
    nxt      = seek(mask_i, int'(cur_q) + 1);
    go       = !busy_q && start_i && en_i && first[CHW];
    store_o  = busy_q && done_i && !abort_i;
    cont     = ((mode_i == MD_SWEEP) && nxt[CHW]) || ((mode_i == MD_LOOP) && first[CHW]);
    wrap     = (mode_i == MD_LOOP) && !nxt[CHW];
    hw_clr_o = store_o && !cont;
    pass_o   = store_o && (!cont || wrap);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q       <= 1'b0;
      conv_start_q <= 1'b0;
      cur_q        <= '0;
    end else begin
      conv_start_q <= 1'b0;
      if (abort_i) begin
        busy_q <= 1'b0;
      end else if (go) begin
        busy_q       <= 1'b1;
        cur_q        <= first[CHW-1:0];
        conv_start_q <= 1'b1;
      end else if (store_o) begin
        if (cont) begin
          cur_q        <= nxt[CHW] ? nxt[CHW-1:0] : first[CHW-1:0];
          conv_start_q <= 1'b1;
        end else begin
          busy_q <= 1'b0;
        end
      end
    end
  end

  assign busy_o       = busy_q;
  assign conv_start_o = conv_start_q;
  assign conv_ch_o    = cur_q;

  // R5
  abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_i |=> (!busy_q && !conv_start_q));

  // R2
  single_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (store_o && (mode_i == MD_ONE)) |=> !busy_q);

endmodule

// File: rtl/adc_res_bank.sv
module adc_res_bank #(
  parameter  int NCH = 8,
  parameter  int DW  = 12,
  localparam int CHW = $clog2(NCH)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    store_i,
  input  logic [CHW-1:0]          store_ch_i,
  input  logic [DW-1:0]           store_data_i,
  input  logic                    rd_i,
  input  logic [CHW-1:0]          rd_ch_i,
  input  logic [NCH-1:0]          ovr_clr_i,
  output logic [NCH-1:0][DW-1:0]  res_o,
  output logic [NCH-1:0]          valid_o,
  output logic [NCH-1:0]          ovr_o
);

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic [DW-1:0] r_q;
    logic          v_q;
    logic          o_q;
    logic          wr_hit;
    logic          rd_hit;

    assign wr_hit = store_i && (store_ch_i == CHW'(g));
    assign rd_hit = rd_i && (rd_ch_i == CHW'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        r_q <= '0;
        v_q <= 1'b0;
        o_q <= 1'b0;
      end else if (wr_hit) begin
        r_q <= store_data_i;
        v_q <= 1'b1;
        if (v_q) o_q <= 1'b1;
      end else begin
        if (rd_hit) v_q <= 1'b0;
        if (ovr_clr_i[g]) o_q <= 1'b0;
      end
    end

    assign res_o[g]   = r_q;
    assign valid_o[g] = v_q;
    assign ovr_o[g]   = o_q;

    // R7
    ovr_prior_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(o_q) |-> $past(v_q));
  end

endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top
  import adc_seq_pkg::*;
#(
  parameter  int NCH         = 8,
  parameter  int DW          = 12,
  parameter  int AW          = 4,
  parameter  int SYNC_STAGES = 2,
  localparam int CHW         = $clog2(NCH),
  localparam int RW          = (CTRL_W > 2 + 2 * NCH) ? CTRL_W : 2 + 2 * NCH
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_wr,
  input  logic           reg_rd,
  input  logic [AW-1:0]  reg_addr,
  input  logic [RW-1:0]  reg_wdata,
  output logic [RW-1:0]  reg_rdata,
  input  logic           trig_pin,
  input  logic           trig_pwm,
  output logic           conv_start,
  output logic [CHW-1:0] conv_ch,
  input  logic           conv_done,
  input  logic [DW-1:0]  conv_data,
  output logic           irq
);

  localparam int ADDR_CTRL = 0;
  localparam int ADDR_MASK = 1;
  localparam int ADDR_STAT = 2;
  localparam int RES_BASE  = NCH;
  localparam int VLD_LSB   = 2;
  localparam int OVR_LSB   = 2 + NCH;

  ctrl_t                 ctrl_q;
  ctrl_t                 wr_ctrl;
  logic [NCH-1:0]        mask_q;
  logic                  cmpl_q;
  logic                  lock_q;
  logic                  start_n;
  logic                  next_en;
  logic                  ctrl_wr;
  logic                  stat_wr;
  logic                  res_hit;
  logic [CHW-1:0]        res_ch;
  logic                  abort;
  logic                  busy;
  logic                  store;
  logic                  hw_clr;
  logic                  pass;
  logic                  trig_fire;
  logic [DW-1:0]         fmt_data;
  logic [NCH-1:0]        ovr_clr;
  logic [NCH-1:0][DW-1:0] res_w;
  logic [NCH-1:0]        valid_w;
  logic [NCH-1:0]        ovr_w;

  assign wr_ctrl = ctrl_t'(reg_wdata[CTRL_W-1:0]);
  assign ctrl_wr = reg_wr && (int'(reg_addr) == ADDR_CTRL);
  assign stat_wr = reg_wr && (int'(reg_addr) == ADDR_STAT);
  assign res_hit = (int'(reg_addr) >= RES_BASE) && (int'(reg_addr) < RES_BASE + NCH);
  assign res_ch  = CHW'(int'(reg_addr) - RES_BASE);
  assign abort   = busy && ctrl_wr && (!wr_ctrl.start || !wr_ctrl.en);
  assign ovr_clr = stat_wr ? reg_wdata[OVR_LSB +: NCH] : '0;
  assign fmt_data = (ctrl_q.diff && ctrl_q.fmt) ? (conv_data ^ {1'b1, {(DW-1){1'b0}}}) : conv_data;

  adc_trig_det #(.STAGES(SYNC_STAGES)) u_trig (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_i  (trig_pin),
    .pwm_i  (trig_pwm),
    .arm_i  (ctrl_q.en && ctrl_q.trig_en),
    .src_i  (ctrl_q.src),
    .cond_i (ctrl_q.cond),
    .fire_o (trig_fire)
  );

  adc_seq_fsm #(.NCH(NCH)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (ctrl_q.start),
    .en_i         (ctrl_q.en),
    .mode_i       (ctrl_q.mode),
    .mask_i       (mask_q),
    .abort_i      (abort),
    .done_i       (conv_done),
    .busy_o       (busy),
    .conv_start_o (conv_start),
    .conv_ch_o    (conv_ch),
    .store_o      (store),
    .hw_clr_o     (hw_clr),
    .pass_o       (pass)
  );

  adc_res_bank #(.NCH(NCH), .DW(DW)) u_bank (
    .clk          (clk),
    .rst_n        (rst_n),
    .store_i      (store),
    .store_ch_i   (conv_ch),
    .store_data_i (fmt_data),
    .rd_i         (reg_rd && res_hit),
    .rd_ch_i      (res_ch),
    .ovr_clr_i    (ovr_clr),
    .res_o        (res_w),
    .valid_o      (valid_w),
    .ovr_o        (ovr_w)
  );

  // start bit: hardware clear and the lockout cycle outrank any set request
  always_comb begin
    start_n = ctrl_q.start;
    if (hw_clr) start_n = 1'b0;
    if (ctrl_wr) start_n = wr_ctrl.start && !lock_q && !hw_clr;
    else if (trig_fire && !lock_q && !hw_clr) start_n = 1'b1;
    next_en = ctrl_wr ? wr_ctrl.en : ctrl_q.en;
    if (!next_en) start_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      mask_q <= '0;
      cmpl_q <= 1'b0;
      lock_q <= 1'b0;
    end else begin
      if (ctrl_wr) ctrl_q <= wr_ctrl;
      ctrl_q.start <= start_n;
      if (reg_wr && (int'(reg_addr) == ADDR_MASK)) mask_q <= reg_wdata[NCH-1:0];
      if (pass) cmpl_q <= 1'b1;
      else if (stat_wr && reg_wdata[1]) cmpl_q <= 1'b0;
      lock_q <= hw_clr;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (int'(reg_addr) == ADDR_CTRL) begin
      reg_rdata[CTRL_W-1:0] = ctrl_q;
    end else if (int'(reg_addr) == ADDR_MASK) begin
      reg_rdata[NCH-1:0] = mask_q;
    end else if (int'(reg_addr) == ADDR_STAT) begin
      reg_rdata[0]                = busy;
      reg_rdata[1]                = cmpl_q;
      reg_rdata[VLD_LSB +: NCH]   = valid_w;
      reg_rdata[OVR_LSB +: NCH]   = ovr_w;
    end else if (res_hit) begin
      reg_rdata[DW-1:0] = res_w[res_ch];
    end
  end

  assign irq = cmpl_q;

  // R9
  off_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q.en |-> !busy);

  // R6
  lockout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |-> !ctrl_q.start);

endmodule

// File: tb/sim_adc_seq_top.sv
module sim_adc_seq_top;

  localparam int NCH = 8;
  localparam int DW  = 12;
  localparam int AW  = 4;
  localparam int RW  = 18;
  localparam int NV  = 6;

  // {mode[38:37], mask[36:29], diff[28], fmt[27], data[26:15], ch[14:12], result[11:0]}
  localparam logic [38:0] VEC [NV] = '{
    {2'd0, 8'h01, 1'b0, 1'b0, 12'h123, 3'd0, 12'h123},
    {2'd0, 8'hA4, 1'b0, 1'b0, 12'hABC, 3'd2, 12'hABC},
    {2'd0, 8'h80, 1'b1, 1'b1, 12'h800, 3'd7, 12'h000},
    {2'd0, 8'h30, 1'b1, 1'b0, 12'h7FF, 3'd4, 12'h7FF},
    {2'd0, 8'h06, 1'b1, 1'b1, 12'h000, 3'd1, 12'h800},
    {2'd1, 8'hFF, 1'b0, 1'b1, 12'hFFF, 3'd0, 12'hFFF}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_wr = 1'b0;
  logic          reg_rd = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [RW-1:0] reg_wdata = '0;
  logic [RW-1:0] reg_rdata;
  logic          trig_pin = 1'b0;
  logic          trig_pwm = 1'b0;
  logic          conv_start;
  logic [2:0]    conv_ch;
  logic          conv_done = 1'b0;
  logic [DW-1:0] conv_data = '0;
  logic          irq;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  adc_seq_top u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_rd     (reg_rd),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .trig_pin   (trig_pin),
    .trig_pwm   (trig_pwm),
    .conv_start (conv_start),
    .conv_ch    (conv_ch),
    .conv_done  (conv_done),
    .conv_data  (conv_data),
    .irq        (irq)
  );

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc >= 50000 && !finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog (all requirements) actual=%0d cycles expected<50000", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int addr, input logic [RW-1:0] data);
    reg_addr  = AW'(addr);
    reg_wdata = data;
    reg_wr    = 1'b1;
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input int addr, output logic [RW-1:0] data);
    reg_addr = AW'(addr);
    reg_rd   = 1'b1;
    #1 data = reg_rdata;
    @(posedge clk);
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic wait_start(input string tag);
    bit seen = 1'b0;
    for (int k = 0; k < 30; k++) begin
      if (conv_start) begin
        seen = 1'b1;
        break;
      end
      @(negedge clk);
    end
    chk(tag, 32'(seen), 32'd1);
  endtask

  task automatic serve(input int ch, input logic [DW-1:0] d, input string tag);
    wait_start({tag, " start"});
    chk({tag, " channel"}, 32'(conv_ch), 32'(ch));
    repeat (3) @(negedge clk);
    conv_data = d;
    conv_done = 1'b1;
    @(negedge clk);
    conv_done = 1'b0;
  endtask

  task automatic quiet(input int n, input string tag);
    bit seen = conv_start;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (conv_start) seen = 1'b1;
    end
    chk(tag, 32'(seen), 32'd0);
  endtask

  initial begin
    logic [RW-1:0] v;
    logic [38:0]   e;
    int            ch;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 and R12: reset values at every mapped address
    rd(0, v);  chk("R1 ctrl after reset", 32'(v), 32'd0);
    rd(1, v);  chk("R1 mask after reset", 32'(v), 32'd0);
    rd(2, v);  chk("R12 status after reset", 32'(v), 32'd0);
    chk("R1 irq after reset", 32'(irq), 32'd0);
    chk("R1 conv_start after reset", 32'(conv_start), 32'd0);

    // R2, R8: table of single conversions
    for (int i = 0; i < NV; i++) begin
      e  = VEC[i];
      ch = int'(e[14:12]);
      wr(1, RW'(e[36:29]));
      wr(2, '1);
      wr(0, RW'(32'h401 | (32'(e[38:37]) << 1) | (32'(e[28]) << 3) | (32'(e[27]) << 4)));
      serve(ch, e[26:15], "R2 single");
      rd(2, v);
      chk("R2 complete flag", 32'(v[1]), 32'd1);
      chk("R2 busy low after single", 32'(v[0]), 32'd0);
      chk("R7 valid set by store", 32'(v[2 + ch]), 32'd1);
      chk("R11 irq follows complete", 32'(irq), 32'd1);
      rd(0, v);
      chk("R2 start cleared by hardware", 32'(v[10]), 32'd0);
      rd(8 + ch, v);
      chk("R8 stored result", 32'(v[11:0]), 32'(e[11:0]));
      rd(2, v);
      chk("R7 valid cleared by read", 32'(v[2 + ch]), 32'd0);
    end

    // R3: single pass scan over channels 0,3,5
    wr(2, '1);
    wr(1, RW'(8'h29));
    wr(0, RW'(32'h405));
    serve(0, 12'h100, "R3 scan");
    serve(3, 12'h103, "R3 scan");
    serve(5, 12'h105, "R3 scan");
    rd(0, v);  chk("R3 start cleared after pass", 32'(v[10]), 32'd0);
    rd(2, v);
    chk("R3 busy low after pass", 32'(v[0]), 32'd0);
    chk("R3 complete after pass", 32'(v[1]), 32'd1);
    quiet(5, "R3 no extra conversion");
    rd(11, v); chk("R3 channel 3 result", 32'(v[11:0]), 32'h103);

    // R4, R5, R7, R11: continuous scan over channels 1,2 then abort
    wr(2, '1);
    rd(9, v);
    rd(10, v);
    wr(1, RW'(8'h06));
    wr(0, RW'(32'h407));
    serve(1, 12'h111, "R4 loop");
    serve(2, 12'h222, "R4 loop");
    serve(1, 12'h333, "R4 wrap");
    chk("R4 next after wrap is channel 2", 32'(conv_ch), 32'd2);
    rd(2, v);
    chk("R4 complete at wrap", 32'(v[1]), 32'd1);
    chk("R4 still busy", 32'(v[0]), 32'd1);
    chk("R7 overrun on channel 1", 32'(v[10 + 1]), 32'd1);
    chk("R7 no overrun on channel 2", 32'(v[10 + 2]), 32'd0);
    rd(10, v);
    chk("R4 channel 2 result", 32'(v[11:0]), 32'h222);
    wr(0, RW'(32'h007));
    rd(2, v);
    chk("R5 busy low after abort", 32'(v[0]), 32'd0);
    chk("R5 conv_start low after abort", 32'(conv_start), 32'd0);
    conv_data = 12'h555;
    conv_done = 1'b1;
    @(negedge clk);
    conv_done = 1'b0;
    rd(2, v);
    chk("R5 late done sets no valid", 32'(v[2 + 2]), 32'd0);
    rd(10, v);
    chk("R5 late done stores nothing", 32'(v[11:0]), 32'h222);
    rd(9, v);
    chk("R7 newer result kept", 32'(v[11:0]), 32'h333);
    wr(2, RW'(32'h1 << (10 + 1)));
    rd(2, v);
    chk("R7 overrun cleared by write", 32'(v[10 + 1]), 32'd0);
    chk("R11 complete kept when bit 1 not written", 32'(v[1]), 32'd1);
    wr(2, RW'(32'h2));
    rd(2, v);
    chk("R11 complete cleared by write", 32'(v[1]), 32'd0);
    chk("R11 irq low", 32'(irq), 32'd0);

    // R6: start write in the cycle after hardware clear is ignored
    wr(1, RW'(8'h10));
    wr(0, RW'(32'h401));
    serve(4, 12'h444, "R6 first");
    wr(0, RW'(32'h401));
    rd(0, v);
    chk("R6 start stays low in lockout", 32'(v[10]), 32'd0);
    quiet(5, "R6 no conversion from locked write");
    wr(0, RW'(32'h401));
    serve(4, 12'h445, "R6 accepted later");
    rd(12, v);
    chk("R6 second result", 32'(v[11:0]), 32'h445);

    // R9: disabled block ignores start
    wr(1, RW'(8'hFF));
    wr(0, RW'(32'h400));
    rd(0, v);
    chk("R9 start reads 0 when disabled", 32'(v[10]), 32'd0);
    quiet(6, "R9 no conversion when disabled");
    rd(2, v);
    chk("R9 busy low when disabled", 32'(v[0]), 32'd0);

    // R10: rising edge on pin, exact latency
    wr(1, RW'(8'h01));
    wr(0, RW'(32'h321));
    repeat (3) @(negedge clk);
    trig_pin = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10 conv_start not before edge k+3", 32'(conv_start), 32'd0);
    @(negedge clk);
    chk("R10 conv_start at edge k+3", 32'(conv_start), 32'd1);
    serve(0, 12'h0C0, "R10 rise");
    quiet(6, "R10 held level does not retrigger edge mode");

    // R10: low level on PWM line, pin ignored
    trig_pwm = 1'b1;
    repeat (3) @(negedge clk);
    wr(0, RW'(32'h0E1));
    quiet(6, "R10 pwm high no fire");
    trig_pin = 1'b0;
    quiet(6, "R10 pin ignored when source is pwm");
    trig_pwm = 1'b0;
    wait_start("R10 low level fires");
    trig_pwm = 1'b1;
    serve(0, 12'h3C3, "R10 level");
    quiet(6, "R10 no retrigger after level released");
    rd(8, v);
    chk("R10 triggered result", 32'(v[11:0]), 32'h3C3);
    wr(0, RW'(32'h001));

    finished = 1'b1;
    summary();
    $finish;
  end

endmodule